// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a small multi-cycle processor that holds one accumulator and executes programs kept in a single synchronous memory. That memory holds both instructions and data words, and every initial value is preloaded. Instruction fetches and data accesses share one address bus, one write-data bus, one read-data bus and one write-enable line. Because of this, only one access can happen in any cycle. The core steps through a fixed control sequence built on named registers: a program counter, an address register, a data register, an instruction register and the accumulator.

Each instruction is one word. The opcode sits in the top four bits and a memory address fills the remaining bits. The core can load, store, add and subtract against memory. It can jump unconditionally, or jump on a zero or a non-negative accumulator. It exchanges values with the outside through two valid/ready ports, and it stops on a halt. An integrator attaches a synchronous RAM whose read data appears one cycle after the request, preloads the program, and releases reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a clock edge, all core registers clear. After that edge `mem_en`, `mem_we`, `in_ready`, `out_valid` and `halted` are low. The first instruction after reset is fetched from address 0.
- R2: An instruction word holds the opcode in bits [15:12] and the operand address in bits [11:0]. Each instruction starts with six cycles: load address register from PC, increment PC, memory read at the old PC (third cycle, `mem_en`=1, `mem_we`=0), capture into the data register, copy to the instruction register, decode.
- R3: There is at most one memory access per cycle. `mem_we`=1 only when `mem_en`=1, and `mem_en`=1 with `mem_we`=0 is a read whose data is returned on `mem_rdata` one cycle later.
- R4: LDA (5), ADD (1) and SUB (2) read the operand address in the seventh cycle. They then load, add or subtract (wrapping modulo 2^16) into the accumulator, for nine cycles in total.
- R5: STA (3) writes the accumulator to the operand address in the seventh cycle, for seven cycles in total.
- R6: BRA (6) always loads PC with the operand. BRZ (7) does so only when the accumulator is zero. BRP (8) does so only when accumulator bit 15 is 0. Each takes six cycles.
- R7: INP (9) holds `in_ready` high from the seventh cycle until a cycle with `in_valid` high. It loads `in_data` into the accumulator at that edge. `in_valid` is ignored in all other cycles.
- R8: OUT (10) holds `out_valid` high from the seventh cycle, with `out_data` equal to the accumulator and stable, until a cycle with `out_ready` high. `out_ready` is ignored otherwise.
- R9: HLT (0) and any unassigned opcode (4, 11 to 15) enter a halted state one cycle after decode. In that state `halted` stays high and there is no memory or port activity until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (valid with mem_en) |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (data register) |
| mem_rdata | input | 16 | Read data, one cycle after a read request |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Core is waiting in an input instruction |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts output word |
| out_data | output | 16 | Output word (accumulator) |
| halted | output | 1 | Core has stopped |

## Verification
The fetch read is due in the third cycle of every instruction. The data read or write is due in the seventh, and an arithmetic result is in the accumulator after the ninth. A waiting input or output phase starts in the seventh cycle and ends the cycle after the handshake. The bench's reference model turns each executed instruction into a list of per-cycle expected port values using exactly those counts. It plays back the input drive for each cycle and compares at the falling edge, half a cycle after the registered outputs change. Data-memory contents are compared with the model's image after the core halts.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_STA = 4'd3,
    OP_LDA = 4'd5,
    OP_BRA = 4'd6,
    OP_BRZ = 4'd7,
    OP_BRP = 4'd8,
    OP_INP = 4'd9,
    OP_OUT = 4'd10
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FMAR,  // address register <= PC
    ST_FINC,  // PC <= PC + 1
    ST_FRD,   // instruction read on the bus
    ST_FMDR,  // data register <= read word
    ST_FCIR,  // instruction register <= data register
    ST_DEC,   // decode / branch / operand address
    ST_DRD,   // operand read on the bus
    ST_DMDR,  // data register <= operand word
    ST_EXEC,  // accumulator update
    ST_DWR,   // accumulator written on the bus
    ST_INW,   // waiting for input word
    ST_OUTW,  // offering output word
    ST_HALT
  } seq_state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     mem_word,
  output logic [W-1:0]     result
);

  always_comb begin
    case (op)
      OP_LDA:  result = mem_word;
      OP_ADD:  result = acc + mem_word;
      OP_SUB:  result = acc - mem_word;
      default: result = acc;
    endcase
  end

endmodule

// File: rtl/acc_cond.sv
module acc_cond
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     acc,
  output logic             take
);

  logic acc_zero;
  logic acc_nonneg;

  assign acc_zero   = (acc == '0);
  assign acc_nonneg = ~acc[W-1];

  always_comb begin
    case (op)
      OP_BRA:  take = 1'b1;
      OP_BRZ:  take = acc_zero;
      OP_BRP:  take = acc_nonneg;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             take,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             ld_mar_pc,
  output logic             inc_pc,
  output logic             ld_mdr_mem,
  output logic             ld_cir,
  output logic             ld_mar_op,
  output logic             ld_mdr_acc,
  output logic             ld_pc_op,
  output logic             ld_acc_alu,
  output logic             ld_acc_in,
  output logic             bus_en,
  output logic             bus_we,
  output logic             in_ready,
  output logic             out_valid,
  output logic             halted
);

  seq_state_e state, state_n;

  always_comb begin
    state_n    = state;
    ld_mar_pc  = 1'b0;
    inc_pc     = 1'b0;
    ld_mdr_mem = 1'b0;
    ld_cir     = 1'b0;
    ld_mar_op  = 1'b0;
    ld_mdr_acc = 1'b0;
    ld_pc_op   = 1'b0;
    ld_acc_alu = 1'b0;
    ld_acc_in  = 1'b0;
    case (state)
      ST_FMAR: begin ld_mar_pc  = 1'b1; state_n = ST_FINC; end
      ST_FINC: begin inc_pc     = 1'b1; state_n = ST_FRD;  end
      ST_FRD:  state_n = ST_FMDR;
      ST_FMDR: begin ld_mdr_mem = 1'b1; state_n = ST_FCIR; end
      ST_FCIR: begin ld_cir     = 1'b1; state_n = ST_DEC;  end
      ST_DEC: begin
        case (opc)
          OP_LDA, OP_ADD, OP_SUB: begin
            ld_mar_op = 1'b1;
            state_n   = ST_DRD;
          end
          OP_STA: begin
            ld_mar_op  = 1'b1;
            ld_mdr_acc = 1'b1;
            state_n    = ST_DWR;
          end
          OP_BRA, OP_BRZ, OP_BRP: begin
            ld_pc_op = take;
            state_n  = ST_FMAR;
          end
          OP_INP:  state_n = ST_INW;
          OP_OUT:  state_n = ST_OUTW;
          default: state_n = ST_HALT;
        endcase
      end
      ST_DRD:  state_n = ST_DMDR;
      ST_DMDR: begin ld_mdr_mem = 1'b1; state_n = ST_EXEC; end
      ST_EXEC: begin ld_acc_alu = 1'b1; state_n = ST_FMAR; end
      ST_DWR:  state_n = ST_FMAR;
      ST_INW: begin
        if (in_valid) begin
          ld_acc_in = 1'b1;
          state_n   = ST_FMAR;
        end
      end
      ST_OUTW: if (out_ready) state_n = ST_FMAR;
      default: state_n = ST_HALT;
    endcase
  end

  // Outputs are registered from the next state so they align with state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FMAR;
      bus_en    <= 1'b0;
      bus_we    <= 1'b0;
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      halted    <= 1'b0;
    end else begin
      state     <= state_n;
      bus_en    <= (state_n == ST_FRD) || (state_n == ST_DRD) || (state_n == ST_DWR);
      bus_we    <= (state_n == ST_DWR);
      in_ready  <= (state_n == ST_INW);
      out_valid <= (state_n == ST_OUTW);
      halted    <= (state_n == ST_HALT);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bus_en && !bus_we && !in_ready && !out_valid && !halted));

  a_r3_write_is_access: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_en);

  a_r7_wait_for_input: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r9_halt_silent: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!bus_en && !in_ready && !out_valid));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              halted
);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mdr;
  logic [DATA_W-1:0] cir;
  logic [DATA_W-1:0] acc;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] alu_y;
  logic              take;

  logic ld_mar_pc, inc_pc, ld_mdr_mem, ld_cir, ld_mar_op;
  logic ld_mdr_acc, ld_pc_op, ld_acc_alu, ld_acc_in;

  assign opc     = cir[DATA_W-1 -: OPC_W];
  assign operand = cir[ADDR_W-1:0];

  acc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .opc        (opc),
    .take       (take),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .ld_mar_pc  (ld_mar_pc),
    .inc_pc     (inc_pc),
    .ld_mdr_mem (ld_mdr_mem),
    .ld_cir     (ld_cir),
    .ld_mar_op  (ld_mar_op),
    .ld_mdr_acc (ld_mdr_acc),
    .ld_pc_op   (ld_pc_op),
    .ld_acc_alu (ld_acc_alu),
    .ld_acc_in  (ld_acc_in),
    .bus_en     (mem_en),
    .bus_we     (mem_we),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .halted     (halted)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .op       (opc),
    .acc      (acc),
    .mem_word (mdr),
    .result   (alu_y)
  );

  acc_cond #(.W(DATA_W)) u_cond (
    .op   (opc),
    .acc  (acc),
    .take (take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      if (ld_mar_pc)       mar <= pc;
      else if (ld_mar_op)  mar <= operand;
      if (inc_pc)          pc  <= pc + 1'b1;
      else if (ld_pc_op)   pc  <= operand;
      if (ld_mdr_mem)      mdr <= mem_rdata;
      else if (ld_mdr_acc) mdr <= acc;
      if (ld_cir)          cir <= mdr;
      if (ld_acc_alu)      acc <= alu_y;
      else if (ld_acc_in)  acc <= in_data;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign out_data  = acc;

  a_r8_output_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_write_data_is_acc: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic        en;
    logic        we;
    logic [11:0] addr;
    logic [15:0] wdata;
    logic        iready;
    logic        ovalid;
    logic [15:0] odata;
    logic        hlt;
    logic        drv_iv;
    logic [15:0] drv_id;
    logic        drv_ordy;
    string       tag;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        halted;

  logic [15:0] bmem [0:4095];
  logic [15:0] mm   [0:4095];
  logic [15:0] inq  [$];
  rec_t        q    [$];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .halted(halted)
  );

  // Synchronous memory: read data one cycle after the request.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  function automatic void push(logic en, logic we, logic [11:0] a, logic [15:0] wd,
                               logic ir, logic ov, logic [15:0] od, logic h,
                               logic iv, logic [15:0] id, logic ordy, string t);
    rec_t r;
    r.en = en; r.we = we; r.addr = a; r.wdata = wd; r.iready = ir;
    r.ovalid = ov; r.odata = od; r.hlt = h; r.drv_iv = iv; r.drv_id = id;
    r.drv_ordy = ordy; r.tag = t;
    q.push_back(r);
  endfunction

  // Idle cycles drive junk handshakes that must be ignored (R7, R8).
  function automatic void idle(string t);
    push(0, 0, 12'h0, 16'h0, 0, 0, 16'h0, 0, 1, 16'hBAD0, 1, t);
  endfunction

  function automatic void put(int a, int op, int operand);
    bmem[a] = {op[3:0], operand[11:0]};
    mm[a]   = {op[3:0], operand[11:0]};
  endfunction

  function automatic void dat(int a, logic [15:0] v);
    bmem[a] = v;
    mm[a]   = v;
  endfunction

  // Instruction-level reference model emitting per-cycle expectations.
  task automatic build_model();
    logic [11:0] pc = 12'h0;
    logic [15:0] acc = 16'h0;
    logic [15:0] w;
    logic [3:0]  op;
    logic [11:0] a;
    string       ftag = "R1";
    int          k = 0;
    bit          run = 1;
    int          guard = 0;
    q.delete();
    while (run && guard < 300) begin
      guard++;
      idle("R2"); idle("R2");
      push(1, 0, pc, 16'h0, 0, 0, 16'h0, 0, 1, 16'hBAD0, 1, ftag); // R2 fetch read
      ftag = "R2";
      w = mm[pc]; op = w[15:12]; a = w[11:0];
      pc = pc + 12'd1;
      idle("R2"); idle("R2"); idle("R2");
      case (op)
        4'd1, 4'd2, 4'd5: begin  // R4
          push(1, 0, a, 16'h0, 0, 0, 16'h0, 0, 1, 16'hBAD0, 1, "R4");
          idle("R4"); idle("R4");
          if (op == 4'd5)      acc = mm[a];
          else if (op == 4'd1) acc = acc + mm[a];
          else                 acc = acc - mm[a];
        end
        4'd3: begin  // R5
          push(1, 1, a, acc, 0, 0, 16'h0, 0, 1, 16'hBAD0, 1, "R5");
          mm[a] = acc;
        end
        4'd6, 4'd7, 4'd8: begin  // R6
          if (op == 4'd6 || (op == 4'd7 && acc == 16'h0) || (op == 4'd8 && !acc[15]))
            pc = a;
          ftag = "R6";
        end
        4'd9: begin  // R7
          for (int d = 0; d < k; d++)
            push(0, 0, 12'h0, 16'h0, 1, 0, 16'h0, 0, 0, 16'h5A5A, 1, "R7");
          acc = inq.pop_front();
          push(0, 0, 12'h0, 16'h0, 1, 0, 16'h0, 0, 1, acc, 1, "R7");
          k = (k + 1) % 4;
        end
        4'd10: begin  // R8
          for (int d = 0; d < k; d++)
            push(0, 0, 12'h0, 16'h0, 0, 1, acc, 0, 1, 16'hBAD0, 0, "R8");
          push(0, 0, 12'h0, 16'h0, 0, 1, acc, 0, 1, 16'hBAD0, 1, "R8");
          k = (k + 1) % 4;
        end
        default: begin  // R9
          for (int d = 0; d < 8; d++)
            push(0, 0, 12'h0, 16'h0, 0, 0, 16'h0, 1, 1, 16'hBAD0, 1, "R9");
          run = 0;
        end
      endcase
    end
  endtask

  task automatic compare(rec_t e);
    bit bad;
    bad = (mem_en !== e.en) || (mem_we !== e.we) ||
          (e.en && mem_addr !== e.addr) || (e.we && mem_wdata !== e.wdata) ||
          (in_ready !== e.iready) || (out_valid !== e.ovalid) ||
          (e.ovalid && out_data !== e.odata) || (halted !== e.hlt);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: actual en=%b we=%b addr=%h wd=%h ir=%b ov=%b od=%h h=%b expected en=%b we=%b addr=%h wd=%h ir=%b ov=%b od=%h h=%b",
               e.tag, mem_en, mem_we, mem_addr, mem_wdata, in_ready, out_valid, out_data, halted,
               e.en, e.we, e.addr, e.wdata, e.iready, e.ovalid, e.odata, e.hlt);
    end
  endtask

  task automatic load_prog(int p);
    for (int i = 0; i < 4096; i++) begin bmem[i] = '0; mm[i] = '0; end
    inq.delete();
    case (p)
      0: begin
        put(0, 9, 0); put(1, 3, 40); put(2, 9, 0); put(3, 1, 40);
        put(4, 10, 0); put(5, 2, 40); put(6, 7, 9); put(7, 10, 0);
        put(8, 0, 0); put(9, 5, 41); put(10, 10, 0); put(11, 0, 0);
        dat(41, 16'h1234);
        inq.push_back(16'd5); inq.push_back(16'd0);
      end
      1: begin
        put(0, 5, 50); put(1, 10, 0); put(2, 2, 51); put(3, 3, 52);
        put(4, 8, 1); put(5, 5, 53); put(6, 1, 51); put(7, 8, 12);
        put(8, 7, 12); put(9, 10, 0); put(10, 6, 13); put(11, 0, 0);
        put(12, 0, 0); put(13, 4, 0);
        dat(50, 16'd3); dat(51, 16'd1); dat(53, 16'h7FFF);
      end
      default: begin
        put(0, 9, 0); put(1, 8, 4); put(2, 9, 0); put(3, 7, 5);
        put(4, 0, 0); put(5, 3, 4095); put(6, 10, 0); put(7, 15, 0);
        inq.push_back(16'hFFFE); inq.push_back(16'h0000);
      end
    endcase
  endtask

  task automatic run_prog(int p);
    int diffs;
    rst = 1'b1;
    load_prog(p);
    build_model();
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (mem_en !== 1'b0 || mem_we !== 1'b0 || in_ready !== 1'b0 ||
        out_valid !== 1'b0 || halted !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual en=%b we=%b ir=%b ov=%b h=%b expected all 0",
               mem_en, mem_we, in_ready, out_valid, halted);
    end
    rst = 1'b0;
    while (q.size() > 0) begin
      rec_t e;
      e = q.pop_front();
      compare(e);
      in_valid  = e.drv_iv;
      in_data   = e.drv_id;
      out_ready = e.drv_ordy;
      @(negedge clk);
    end
    diffs = 0;
    for (int i = 0; i < 4096; i++) if (bmem[i] !== mm[i]) diffs++;
    checks++;  // R5 memory image after run
    if (diffs != 0) begin
      fails++;
      $display("FAIL R5: actual %0d differing words, expected 0", diffs);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    run_prog(0);
    run_prog(1);
    run_prog(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule